// File: doc/BRIEF.md
# Text-Mode Raster Timing Generator

This block produces the complete raster timing for an 80-column colour text screen. It runs from the 14.31818 MHz dot clock and derives a character-time enable internally, one pulse for every eight dot clocks. It keeps a column counter, a scanline-within-row counter and a character-row counter. From these it decodes horizontal sync, vertical sync and a display-enable flag, which the colour path uses to blank its outputs outside the visible rectangle.

For the fetch stage that follows, the block also presents a linear character address and the scanline number within the current character row. The geometry is fixed at build time. A line is 114 character times, so the line rate is about 15.70 kHz. A field is 262 lines, so the field rate is about 59.92 Hz.

Every port is a plain control or timing pin. No data stream crosses the block boundary, so there is no valid/ready handshake and no back-pressure.

Top module: `crt_text_timing`

## Requirements
- R1: The column, scanline and row counters advance only on the character-time enable. With the default divider `CHAR_DIV` = 8, this enable fires on every eighth dot clock after reset is released. With `CHAR_DIV` = 1 it fires on every dot clock.
- R2: A line lasts 114 character times, numbered column 0 to 113. Only columns 0 to 79 may be visible.
- R3: `hsync` is high exactly for columns 90 to 99, which is 10 character times per line.
- R4: A frame lasts 262 lines. These are 32 character rows of 8 scanlines each (lines 0 to 255), then 6 adjust scanlines (lines 256 to 261). After that the frame restarts at line 0.
- R5: `disp_en` is high exactly when the column is 0 to 79 and the line is 0 to 199 (character rows 0 to 24). It is low everywhere else.
- R6: `vsync` is high exactly for lines 224 to 239. That is 16 scanlines, starting at the top of character row 28.
- R7: While `disp_en` is high, `char_addr` equals 80 × row + column. The address is therefore 0 at the top-left of each frame and steps by 80 per character row. While `disp_en` is low, `char_addr` is 0.
- R8: During character rows, `scan_line` equals the line number modulo 8, so it counts 0 to 7 and returns to 0 at each new row. During the adjust scanlines it counts 0 to 5.
- R9: While `rst_n` is sampled low at a clock edge, all counters return to zero. While `rst_n` is low, `hsync`, `vsync`, `disp_en`, `char_addr` and `scan_line` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_dot | input | 1 | 14.31818 MHz dot clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| disp_en | output | 1 | High inside the visible rectangle |
| char_addr | output | 11 | Linear character address for the fetch stage |
| scan_line | output | 3 | Scanline within the current character row |

## Verification
The bench compares every output on every dot clock against a model indexed only by the count of clocks since reset. It runs two instances. The default instance uses a divide-by-8 character clock. The second uses a divide-by-1 character clock, so that several whole frames fit in the run and the frame wrap is covered.

The corner cases targeted are these:
- Off-by-one edges at columns 79/80, 89/90 and 99/100. A wrong comparison there shifts blanking or sync by one character.
- The row-24/25 boundary. Getting it wrong either leaks a 26th visible row or lets the address run past 1999.
- The vsync window at lines 224 and 240.
- The switch from row 31 into the six adjust lines and back to line 0. A design without the adjust phase would produce a 256-line frame, and the drift would show up within one frame.

A reset is also applied at a randomly chosen point in the middle of a frame. A design that resets only some of its counters would then fall out of step with the model.

// File: rtl/crt_text_pkg.sv
package crt_text_pkg;
  // horizontal geometry, in character times
  localparam int H_TOTAL      = 114;
  localparam int H_DISP       = 80;
  localparam int HS_START     = 90;
  localparam int HS_LEN       = 10;
  // vertical geometry
  localparam int SCAN_PER_ROW = 8;
  localparam int V_ROWS       = 32;
  localparam int V_ADJ        = 6;
  localparam int V_DISP_ROWS  = 25;
  localparam int VS_START_ROW = 28;
  localparam int VS_LEN       = 16;
  // derived
  localparam int LINE_TOTAL   = V_ROWS * SCAN_PER_ROW + V_ADJ;
  localparam int COL_W        = $clog2(H_TOTAL);
  localparam int ROW_W        = $clog2(V_ROWS);
  localparam int SCAN_W       = $clog2(SCAN_PER_ROW);
  localparam int LINE_W       = $clog2(LINE_TOTAL);
  localparam int ADDR_W       = $clog2(V_DISP_ROWS * H_DISP);
  localparam int VS_FIRST     = VS_START_ROW * SCAN_PER_ROW;
  localparam int VS_LAST      = VS_FIRST + VS_LEN - 1;
endpackage

// File: rtl/crt_char_tick.sv
module crt_char_tick #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_pass
      assign tick = 1'b1;
    end else begin : g_count
      localparam int CW = $clog2(DIV);
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);
      logic [CW-1:0] cnt;
      always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (tick)   cnt <= '0;
        else             cnt <= cnt + 1'b1;
      end
      assign tick = (cnt == LAST);

      // R1: between ticks there are exactly DIV-1 idle clocks
      assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/crt_hcount.sv
module crt_hcount
  import crt_text_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  output logic [COL_W-1:0] col,
  output logic             line_end,
  output logic             hsync,
  output logic             h_vis
);
  localparam logic [COL_W-1:0] COL_LAST = COL_W'(H_TOTAL - 1);
  localparam logic [COL_W-1:0] COL_VIS  = COL_W'(H_DISP);
  localparam logic [COL_W-1:0] COL_HS0  = COL_W'(HS_START);
  localparam logic [COL_W-1:0] COL_HS1  = COL_W'(HS_START + HS_LEN);

  always_ff @(posedge clk) begin
    if (!rst_n)        col <= '0;
    else if (line_end) col <= '0;
    else if (tick)     col <= col + 1'b1;
  end

  assign line_end = tick && (col == COL_LAST);
  assign h_vis    = (col < COL_VIS);
  assign hsync    = (col >= COL_HS0) && (col < COL_HS1);

  // R1: column holds when no character tick
  assert_col_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(col));
  // R2: column steps by one inside the line
  assert_col_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && col != COL_LAST) |=> col == $past(col) + 1'b1);
  // R9: reset clears the column
  assert_col_reset_R9: assert property (@(posedge clk)
    !rst_n |=> col == '0);
endmodule

// File: rtl/crt_vcount.sv
module crt_vcount
  import crt_text_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_end,
  output logic [SCAN_W-1:0] scan_out,
  output logic [ADDR_W-1:0] row_base,
  output logic              v_vis,
  output logic              vsync
);
  localparam logic [SCAN_W-1:0] SCAN_LAST = SCAN_W'(SCAN_PER_ROW - 1);
  localparam logic [SCAN_W-1:0] ADJ_LAST  = SCAN_W'(V_ADJ - 1);
  localparam logic [ROW_W-1:0]  ROW_LAST  = ROW_W'(V_ROWS - 1);
  localparam logic [ROW_W-1:0]  ROW_VIS   = ROW_W'(V_DISP_ROWS);
  localparam logic [ROW_W-1:0]  ROW_VIS_L = ROW_W'(V_DISP_ROWS - 1);
  localparam logic [ADDR_W-1:0] ROW_STEP  = ADDR_W'(H_DISP);
  localparam logic [LINE_W-1:0] ADJ_BASE  = LINE_W'(V_ROWS * SCAN_PER_ROW);
  localparam logic [LINE_W-1:0] VS_LO     = LINE_W'(VS_FIRST);
  localparam logic [LINE_W-1:0] VS_HI     = LINE_W'(VS_LAST);

  logic [ROW_W-1:0]  row;
  logic [SCAN_W-1:0] scan;
  logic [SCAN_W-1:0] adj_cnt;
  logic              in_adj;
  logic [LINE_W-1:0] vline;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row      <= '0;
      scan     <= '0;
      adj_cnt  <= '0;
      in_adj   <= 1'b0;
      row_base <= '0;
    end else if (line_end) begin
      if (in_adj) begin
        if (adj_cnt == ADJ_LAST) begin
          in_adj   <= 1'b0;
          adj_cnt  <= '0;
          row      <= '0;
          scan     <= '0;
          row_base <= '0;
        end else begin
          adj_cnt <= adj_cnt + 1'b1;
        end
      end else if (scan == SCAN_LAST) begin
        scan <= '0;
        if (row == ROW_LAST) begin
          if (V_ADJ > 0) begin
            in_adj  <= 1'b1;
            adj_cnt <= '0;
          end else begin
            row      <= '0;
            row_base <= '0;
          end
        end else begin
          row <= row + 1'b1;
          if (row < ROW_VIS_L) row_base <= row_base + ROW_STEP;
        end
      end else begin
        scan <= scan + 1'b1;
      end
    end
  end

  assign vline    = in_adj ? (ADJ_BASE + LINE_W'(adj_cnt))
                           : LINE_W'({row, scan});
  assign vsync    = (vline >= VS_LO) && (vline <= VS_HI);
  assign v_vis    = !in_adj && (row < ROW_VIS);
  assign scan_out = in_adj ? adj_cnt : scan;

  // R8: scanline steps by one inside a character row
  assert_scan_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (line_end && !in_adj && scan != SCAN_LAST) |=> scan == $past(scan) + 1'b1);
  // R4: adjust phase always starts at count zero after the last row
  assert_adj_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_adj) |-> (adj_cnt == '0 && $past(row) == ROW_LAST));
  // R7: row base stays within the visible address space
  assert_base_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    row_base <= ADDR_W'((V_DISP_ROWS - 1) * H_DISP));
endmodule

// File: rtl/crt_text_timing.sv
module crt_text_timing
  import crt_text_pkg::*;
#(
  parameter int CHAR_DIV = 8
) (
  input  logic              clk_dot,
  input  logic              rst_n,
  output logic              hsync,
  output logic              vsync,
  output logic              disp_en,
  output logic [ADDR_W-1:0] char_addr,
  output logic [SCAN_W-1:0] scan_line
);
  logic              tick;
  logic [COL_W-1:0]  col;
  logic              line_end;
  logic              hs_raw, vs_raw, h_vis, v_vis;
  logic [SCAN_W-1:0] scan_raw;
  logic [ADDR_W-1:0] row_base;

  crt_char_tick #(.DIV(CHAR_DIV)) u_tick (
    .clk   (clk_dot),
    .rst_n (rst_n),
    .tick  (tick)
  );

  crt_hcount u_h (
    .clk      (clk_dot),
    .rst_n    (rst_n),
    .tick     (tick),
    .col      (col),
    .line_end (line_end),
    .hsync    (hs_raw),
    .h_vis    (h_vis)
  );

  crt_vcount u_v (
    .clk      (clk_dot),
    .rst_n    (rst_n),
    .line_end (line_end),
    .scan_out (scan_raw),
    .row_base (row_base),
    .v_vis    (v_vis),
    .vsync    (vs_raw)
  );

  assign disp_en   = rst_n && h_vis && v_vis;
  assign hsync     = rst_n && hs_raw;
  assign vsync     = rst_n && vs_raw;
  assign char_addr = disp_en ? (row_base + ADDR_W'(col)) : '0;
  assign scan_line = rst_n ? scan_raw : '0;

  // R5: syncs never overlap the visible rectangle
  assert_blank_in_sync_R5: assert property (@(posedge clk_dot) disable iff (!rst_n)
    (hsync || vsync) |-> !disp_en);
  // R7: address steps by one between visible characters of a row
  assert_addr_step_R7: assert property (@(posedge clk_dot) disable iff (!rst_n)
    (disp_en && tick && col != COL_W'(H_DISP - 1)) |=> char_addr == $past(char_addr) + 1'b1);
  // R9: outputs quiet while reset is held
  assert_reset_quiet_R9: assert property (@(posedge clk_dot)
    !rst_n |-> (!hsync && !vsync && !disp_en && char_addr == '0 && scan_line == '0));
endmodule

// File: tb/crt_text_timing_test.sv
module crt_text_timing_test;
  localparam int CLK_PERIOD = 70;
  localparam int RUN_CYCLES = 120000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        hs_s, vs_s, de_s, hs_f, vs_f, de_f;
  logic [10:0] ad_s, ad_f;
  logic [2:0]  sc_s, sc_f;

  crt_text_timing uut (
    .clk_dot(clk), .rst_n(rst_n), .hsync(hs_s), .vsync(vs_s),
    .disp_en(de_s), .char_addr(ad_s), .scan_line(sc_s));

  crt_text_timing #(.CHAR_DIV(1)) uut_fast (
    .clk_dot(clk), .rst_n(rst_n), .hsync(hs_f), .vsync(vs_f),
    .disp_en(de_f), .char_addr(ad_f), .scan_line(sc_f));

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic bit e_de(int c, int l); return (c < 80) && (l < 200); endfunction
  function automatic bit e_hs(int c);        return (c >= 90) && (c < 100); endfunction
  function automatic bit e_vs(int l);        return (l >= 224) && (l < 240); endfunction
  function automatic int e_addr(int c, int l);
    return e_de(c, l) ? (l / 8) * 80 + c : 0;
  endfunction
  function automatic int e_scan(int l);
    return (l < 256) ? l % 8 : l - 256;
  endfunction

  task automatic check_inst(input string who, input int k, input int div,
                            input logic hs, input logic vs, input logic de,
                            input int ad, input int sc);
    int n, c, l;
    if (!rst_n) begin
      chk("R9", {who, " hsync"}, hs, 0);
      chk("R9", {who, " vsync"}, vs, 0);
      chk("R9", {who, " disp_en"}, de, 0);
      chk("R9", {who, " char_addr"}, ad, 0);
      chk("R9", {who, " scan_line"}, sc, 0);
    end else begin
      n = k / div;          // R1: character ticks since reset
      c = n % 114;          // R2
      l = (n / 114) % 262;  // R4
      chk("R3 R1", {who, " hsync"}, hs, e_hs(c));
      chk("R6 R4", {who, " vsync"}, vs, e_vs(l));
      chk("R5 R2", {who, " disp_en"}, de, e_de(c, l));
      chk("R7", {who, " char_addr"}, ad, e_addr(c, l));
      chk("R8 R4", {who, " scan_line"}, sc, e_scan(l));
    end
  endtask

  initial begin
    int k;
    int rst_at, rst_len;
    void'($urandom(32'd20240611));
    rst_at  = 40000 + $urandom_range(0, 20000);
    rst_len = 1 + $urandom_range(0, 4);
    k = 0;
    for (int cyc = 0; cyc < RUN_CYCLES; cyc++) begin
      @(negedge clk);
      if (rst_n) k++; else k = 0;
      check_inst("div8", k, 8, hs_s, vs_s, de_s, ad_s, sc_s);
      check_inst("div1", k, 1, hs_f, vs_f, de_f, ad_f, sc_f);
      if (cyc == 3) rst_n = 1'b1;
      if (cyc == rst_at) rst_n = 1'b0;
      if (cyc == rst_at + rst_len) rst_n = 1'b1;
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * (RUN_CYCLES + 20000));
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule